// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a small in-order queue that sits between the retire point of a core and its data memory. Committed stores are written into it and wait there until the memory side accepts them, one at a time, oldest first, through a valid/ready handshake. Younger loads are checked against every store still waiting, so a load sees the most recent pending write without a trip to memory.

A load presents its full word address and a byte-enable mask. Every live entry with the same full address is a candidate, and the youngest candidate decides the result. If that entry writes every byte the load asks for, its data is returned at once and no memory read is issued. If it writes only some of those bytes, the load is told to stall and gets no data. If no entry matches, the load goes out on the memory read port unchanged. A separate kill port takes a slot number, handed out when the store was accepted, and cancels that entry so that it is never written to memory and never forwarded again.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `mw_valid` is 0, and any load is a miss (`mrd_valid` 1, `ld_hit` 0, `ld_stall` 0).
- R2: A store is accepted on a clock edge where `st_valid` and `st_ready` are both 1, and goes into the slot shown on `st_tag` in that cycle. Slots are handed out in rising order and wrap. With DEPTH entries occupied `st_ready` is 0, the offered store is dropped, and no entry changes.
- R3: The memory write port offers the oldest occupied entry. It pops that entry only on an edge where `mw_valid` and `mw_ready` are both 1. While it waits, the address, data and byte enables stay stable.
- R4: A load compares its full `ld_addr` with the address of every live entry. A match whose byte enables cover every bit set in `ld_be` gives `ld_hit` 1 and puts the entry's data on `ld_data`, with `mrd_valid` 0.
- R5: When several live entries match, the youngest one in acceptance order decides the result and supplies the data.
- R6: If the youngest matching entry lacks any byte set in `ld_be`, `ld_stall` is 1, while `ld_hit` and `mrd_valid` are 0.
- R7: A load with no live match drives `mrd_valid` 1, with `mrd_addr` equal to `ld_addr` and `mrd_be` equal to `ld_be`. Without `ld_valid`, `ld_hit`, `ld_stall` and `mrd_valid` are all 0.
- R8: `inv_valid` with slot `inv_tag` cancels that entry from the next cycle on. It is never offered to memory and never forwarded. When it reaches the head, its slot is freed without a handshake.
- R9: A store is visible to loads from the cycle after it is accepted. It stays visible up to and including the cycle in which its write handshake completes.
- R10: A kill aimed at the current head lowers `mw_valid` in that same cycle, so the entry can never be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_tag | output | log2(DEPTH) | Slot the offered store will occupy |
| inv_valid | input | 1 | Cancel an entry |
| inv_tag | input | log2(DEPTH) | Slot to cancel |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Bytes the load needs |
| ld_hit | output | 1 | Load fully served from the queue |
| ld_stall | output | 1 | Partial overlap, load must retry |
| ld_data | output | DW | Forwarded data (zero unless hit) |
| mrd_valid | output | 1 | Load sent to memory |
| mrd_addr | output | AW | Memory read address |
| mrd_be | output | DW/8 | Memory read byte enables |
| mw_valid | output | 1 | Oldest entry offered to memory |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | AW | Write address |
| mw_data | output | DW | Write data |
| mw_be | output | DW/8 | Write byte enables |

## Verification
The bench fills the queue so that one address is written twice, the younger write covering fewer bytes. It then sweeps loads over every byte mask against each stored address, an absent address, and an address that differs only in a high bit. A design that picks the oldest match, or that compares only low address bits, returns stale data or false hits here. A design that merges partial data hands out a hit where a stall is due. Kills are aimed at a mid-queue entry and at the head while memory is ready. A design that lets a cancelled store leak would show `mw_valid` on a dead entry or keep forwarding its data. A long pseudo-random phase mixes pushes at full occupancy, wrap-around, back-pressured drains and same-cycle load lookups. This catches overwrites on a full queue and slots that free too early or too late.

// File: rtl/sb_pkg.sv
// Package: shared types for the store queue.
package sb_pkg;
    // Result of a load lookup against the pending stores
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_MISS  = 2'd1,
        LD_HIT   = 2'd2,
        LD_STALL = 2'd3
    } ld_kind_t;
endpackage

// File: rtl/sb_ring_ctrl.sv
// Ring pointer and occupancy control for the store queue.
// Assumes DEPTH is a power of two of at least 2, so pointers wrap naturally.
// Caller guarantees push only when not full and pop only when not empty.
module sb_ring_ctrl #(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    // Advance the pointers and the occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop)  head <= head + PW'(1);
            if (push) tail <= tail + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/sb_slot.sv
// One store-queue entry: live flag, word address, data and byte enables.
// A set in the same cycle as a clear wins; the caller never sets a live slot.
module sb_slot #(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic          clr,
    input  logic [AW-1:0] d_addr,
    input  logic [DW-1:0] d_data,
    input  logic [BW-1:0] d_be,
    output logic          q_vld,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_data,
    output logic [BW-1:0] q_be
);
    // Capture a new store or drop the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_addr <= '0;
            q_data <= '0;
            q_be   <= '0;
        end else if (set) begin
            q_vld  <= 1'b1;
            q_addr <= d_addr;
            q_data <= d_data;
            q_be   <= d_be;
        end else if (clr) begin
            q_vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/sb_fwd_select.sv
// Load lookup: compares the full load address with every live entry, walks
// the ring from head (oldest) to youngest so the last match wins, then
// classifies the load as hit, partial-overlap stall or miss.
// Assumes DEPTH is a power of two so head+k wraps in PW bits.
module sb_fwd_select
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [PW-1:0]            head,
    input  logic [DEPTH-1:0]         e_vld,
    input  logic [DEPTH-1:0][AW-1:0] e_addr,
    input  logic [DEPTH-1:0][DW-1:0] e_data,
    input  logic [DEPTH-1:0][BW-1:0] e_be,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    input  logic [BW-1:0]            ld_be,
    output ld_kind_t                 kind,
    output logic [DW-1:0]            fwd_data
);
    logic [DEPTH-1:0] match;
    logic             found;
    logic [PW-1:0]    sel;
    logic [PW-1:0]    idx;
    logic [BW-1:0]    missing;

    // Full-address comparators, one per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = e_vld[i] && (e_addr[i] == ld_addr);
    end

    // Age-ordered scan: the youngest matching slot is the last one seen
    always_comb begin
        found = 1'b0;
        sel   = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (match[idx]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
    end

    // Classify the load and steer forwarded data
    always_comb begin
        missing  = ld_be & ~e_be[sel];
        fwd_data = '0;
        if (!ld_valid) begin
            kind = LD_NONE;
        end else if (!found) begin
            kind = LD_MISS;
        end else if (|missing) begin
            kind = LD_STALL;
        end else begin
            kind     = LD_HIT;
            fwd_data = e_data[sel];
        end
    end
endmodule

// File: rtl/store_fwd_buf.sv
// Store queue with load forwarding. Retired stores enter at the tail, drain
// oldest-first to memory through a valid/ready handshake, and serve younger
// loads by full-address match with youngest-entry priority. A kill port
// cancels one slot; a cancelled head is freed without a memory write.
// Assumes DEPTH is a power of two, at least 2.
module store_fwd_buf
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    output logic [PW-1:0] st_tag,
    input  logic          inv_valid,
    input  logic [PW-1:0] inv_tag,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [BW-1:0] ld_be,
    output logic          ld_hit,
    output logic          ld_stall,
    output logic [DW-1:0] ld_data,
    output logic          mrd_valid,
    output logic [AW-1:0] mrd_addr,
    output logic [BW-1:0] mrd_be,
    output logic          mw_valid,
    input  logic          mw_ready,
    output logic [AW-1:0] mw_addr,
    output logic [DW-1:0] mw_data,
    output logic [BW-1:0] mw_be
);
    logic [PW-1:0]            head_ptr;
    logic [PW-1:0]            tail_ptr;
    logic [CW-1:0]            occ_cnt;
    logic                     q_full;
    logic                     q_empty;
    logic                     push_acc;
    logic                     pop_en;
    logic                     head_live;
    logic                     kill_head;
    logic [DEPTH-1:0]         set_vec;
    logic [DEPTH-1:0]         clr_vec;
    logic [DEPTH-1:0]         slot_vld;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic [DEPTH-1:0][BW-1:0] slot_be;
    ld_kind_t                 ld_kind;

    // Accept side
    assign st_ready = !q_full;
    assign st_tag   = tail_ptr;
    assign push_acc = st_valid && st_ready;

    // Drain side: offer the head only if it is still live and not being killed
    assign head_live = slot_vld[head_ptr];
    assign kill_head = inv_valid && (inv_tag == head_ptr);
    assign mw_valid  = !q_empty && head_live && !kill_head;
    assign mw_addr   = slot_addr[head_ptr];
    assign mw_data   = slot_data[head_ptr];
    assign mw_be     = slot_be[head_ptr];
    assign pop_en    = !q_empty && (!head_live || (mw_valid && mw_ready));

    sb_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_acc),
        .pop   (pop_en),
        .head  (head_ptr),
        .tail  (tail_ptr),
        .count (occ_cnt),
        .full  (q_full),
        .empty (q_empty)
    );

    // Entry storage, one slot per ring position
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign set_vec[i] = push_acc && (tail_ptr == PW'(i));
        assign clr_vec[i] = (pop_en && (head_ptr == PW'(i)))
                          || (inv_valid && (inv_tag == PW'(i)));
        sb_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (set_vec[i]),
            .clr    (clr_vec[i]),
            .d_addr (st_addr),
            .d_data (st_data),
            .d_be   (st_be),
            .q_vld  (slot_vld[i]),
            .q_addr (slot_addr[i]),
            .q_data (slot_data[i]),
            .q_be   (slot_be[i])
        );
    end

    sb_fwd_select #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .head     (head_ptr),
        .e_vld    (slot_vld),
        .e_addr   (slot_addr),
        .e_data   (slot_data),
        .e_be     (slot_be),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_be    (ld_be),
        .kind     (ld_kind),
        .fwd_data (ld_data)
    );

    // Load result decode and miss pass-through
    assign ld_hit    = (ld_kind == LD_HIT);
    assign ld_stall  = (ld_kind == LD_STALL);
    assign mrd_valid = (ld_kind == LD_MISS);
    assign mrd_addr  = ld_addr;
    assign mrd_be    = ld_be;
endmodule

// File: rtl/sb_chk.sv
// Assertion checker for store_fwd_buf, attached with bind below.
module sb_chk #(
    parameter int DEPTH = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int BW = DW / 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inv_valid,
    input logic [PW-1:0]    inv_tag,
    input logic             ld_valid,
    input logic             ld_hit,
    input logic             ld_stall,
    input logic             mrd_valid,
    input logic             mw_valid,
    input logic             mw_ready,
    input logic [AW-1:0]    mw_addr,
    input logic [DW-1:0]    mw_data,
    input logic [BW-1:0]    mw_be,
    input logic             push_acc,
    input logic             pop_en,
    input logic [PW-1:0]    tail_ptr,
    input logic [CW-1:0]    occ_cnt,
    input logic [DEPTH-1:0] slot_vld
);
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CW'(DEPTH));

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && !pop_en) |=> occ_cnt == $past(occ_cnt) + CW'(1));

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_acc) |=> occ_cnt == $past(occ_cnt) - CW'(1));

    p_hold_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready && !inv_valid)
        |=> ($stable(mw_addr) && $stable(mw_data) && $stable(mw_be)));

    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_hit, ld_stall, mrd_valid}));

    p_load_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hit || ld_stall || mrd_valid) == ld_valid);

    p_kill_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !(push_acc && (tail_ptr == inv_tag)))
        |=> !slot_vld[$past(inv_tag)]);
endmodule

bind store_fwd_buf sb_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_valid (inv_valid),
    .inv_tag   (inv_tag),
    .ld_valid  (ld_valid),
    .ld_hit    (ld_hit),
    .ld_stall  (ld_stall),
    .mrd_valid (mrd_valid),
    .mw_valid  (mw_valid),
    .mw_ready  (mw_ready),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data),
    .mw_be     (mw_be),
    .push_acc  (push_acc),
    .pop_en    (pop_en),
    .tail_ptr  (tail_ptr),
    .occ_cnt   (occ_cnt),
    .slot_vld  (slot_vld)
);

// File: tb/tb_store_fwd_buf.sv
`timescale 1ns/1ps
module tb_store_fwd_buf;
    localparam int DEPTH = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, inv_valid = 0, ld_valid = 0, mw_ready = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0, ld_be = '0;
    logic [PW-1:0] inv_tag = '0;
    logic st_ready, ld_hit, ld_stall, mrd_valid, mw_valid;
    logic [PW-1:0] st_tag;
    logic [DW-1:0] ld_data, mw_data;
    logic [AW-1:0] mrd_addr, mw_addr;
    logic [BW-1:0] mrd_be, mw_be;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    store_fwd_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_tag(st_tag),
        .inv_valid(inv_valid), .inv_tag(inv_tag),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
        .mrd_valid(mrd_valid), .mrd_addr(mrd_addr), .mrd_be(mrd_be),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
        .mw_data(mw_data), .mw_be(mw_be)
    );

    // Requirement-level model of the queue, advanced on each clock edge
    logic [AW-1:0] m_addr [DEPTH];
    logic [DW-1:0] m_data [DEPTH];
    logic [BW-1:0] m_be   [DEPTH];
    bit            m_val  [DEPTH];
    int m_head = 0;
    int m_cnt = 0;

    function automatic bit exp_mw_valid();
        return (m_cnt > 0) && m_val[m_head] && !(inv_valid && (int'(inv_tag) == m_head));
    endfunction

    always @(posedge clk) begin : model
        int tl;
        bit do_pop, do_push;
        if (!rst_n) begin
            m_head = 0;
            m_cnt = 0;
            for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
        end else begin
            tl = (m_head + m_cnt) % DEPTH;
            do_pop = (m_cnt > 0) && (!m_val[m_head] || (exp_mw_valid() && mw_ready));
            do_push = st_valid && (m_cnt < DEPTH);
            if (inv_valid) m_val[inv_tag] = 0;
            if (do_pop) begin
                m_val[m_head] = 0;
                m_head = (m_head + 1) % DEPTH;
            end
            if (do_push) begin
                m_val[tl] = 1;
                m_addr[tl] = st_addr;
                m_data[tl] = st_data;
                m_be[tl] = st_be;
            end
            m_cnt = m_cnt + int'(do_push) - int'(do_pop);
        end
    end

    task automatic ck(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
        end
    endtask

    // Compare every output with the model for the current cycle
    task automatic check_all();
        bit mwv, found;
        int sel;
        mwv = exp_mw_valid();
        ck("R2 st_ready", st_ready, m_cnt < DEPTH);
        if (m_cnt < DEPTH) ck("R2 st_tag", st_tag, (m_head + m_cnt) % DEPTH);
        ck("R3/R8/R10 mw_valid", mw_valid, mwv);
        if (mwv) begin
            ck("R3 mw_addr", mw_addr, m_addr[m_head]);
            ck("R3 mw_data", mw_data, m_data[m_head]);
            ck("R3 mw_be", mw_be, m_be[m_head]);
        end
        found = 0;
        sel = 0;
        for (int k = 0; k < DEPTH; k++) begin
            int ix;
            ix = (m_head + k) % DEPTH;
            if (m_val[ix] && m_addr[ix] == ld_addr) begin
                found = 1;
                sel = ix;
            end
        end
        if (!ld_valid) begin
            ck("R7 idle hit", ld_hit, 0);
            ck("R7 idle stall", ld_stall, 0);
            ck("R7 idle mrd", mrd_valid, 0);
        end else if (!found) begin
            ck("R7 miss mrd_valid", mrd_valid, 1);
            ck("R7 miss mrd_addr", mrd_addr, ld_addr);
            ck("R7 miss mrd_be", mrd_be, ld_be);
            ck("R4 miss hit", ld_hit, 0);
            ck("R6 miss stall", ld_stall, 0);
        end else if ((ld_be & ~m_be[sel]) != 0) begin
            ck("R6 partial stall", ld_stall, 1);
            ck("R6 partial hit", ld_hit, 0);
            ck("R6 partial mrd", mrd_valid, 0);
        end else begin
            ck("R4/R9 hit", ld_hit, 1);
            ck("R5 youngest data", ld_data, m_data[sel]);
            ck("R4 no mem read", mrd_valid, 0);
            ck("R6 hit stall", ld_stall, 0);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, then check
    task automatic cyc(bit sv, logic [AW-1:0] sa, logic [DW-1:0] sd, logic [BW-1:0] sb,
                       bit iv, logic [PW-1:0] it, bit lv, logic [AW-1:0] la,
                       logic [BW-1:0] lb, bit mr);
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
        inv_valid = iv; inv_tag = it;
        ld_valid = lv; ld_addr = la; ld_be = lb;
        mw_ready = mr;
        #1;
        check_all();
    endtask

    task automatic sweep_loads();
        logic [AW-1:0] addrs [5];
        addrs[0] = 16'h0010; addrs[1] = 16'h0020; addrs[2] = 16'h0030;
        addrs[3] = 16'h0040; addrs[4] = 16'h8010;
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 16; b++)
                cyc(0, '0, '0, '0, 0, '0, 1, addrs[a], BW'(b), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] r;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: empty after reset
        ck("R1 st_ready", st_ready, 1);
        ck("R1 mw_valid", mw_valid, 0);
        cyc(0, '0, '0, '0, 0, '0, 1, 16'h0010, 4'hF, 0);
        ck("R1 load misses", mrd_valid, 1);
        ck("R1 no hit", ld_hit, 0);

        // Fill: address 0x0010 written twice, younger write covers fewer bytes
        cyc(1, 16'h0010, 32'hA1A1A1A1, 4'hF, 0, '0, 0, '0, '0, 0);
        cyc(1, 16'h0020, 32'hB2B2B2B2, 4'h3, 0, '0, 1, 16'h0010, 4'hF, 0); // R9 first store visible
        cyc(1, 16'h0010, 32'hC3C3C3C3, 4'hC, 0, '0, 0, '0, '0, 0);
        cyc(1, 16'h0030, 32'hD4D4D4D4, 4'hF, 0, '0, 0, '0, '0, 0);
        // R2: push while full is dropped
        cyc(1, 16'h0040, 32'hEEEEEEEE, 4'hF, 0, '0, 1, 16'h0040, 4'hF, 0);
        cyc(0, '0, '0, '0, 0, '0, 1, 16'h0040, 4'hF, 0);
        ck("R2 full push dropped", mrd_valid, 1);
        sweep_loads();
        // R8: cancel the younger 0x0010 store (slot 2), older one takes over
        cyc(0, '0, '0, '0, 1, 2'd2, 0, '0, '0, 0);
        sweep_loads();
        // R10: kill the head while memory is ready
        cyc(0, '0, '0, '0, 1, PW'(m_head), 0, '0, '0, 1);
        ck("R10 killed head not offered", mw_valid, 0);
        // Drain the rest, looking up loads during the drain
        for (int i = 0; i < 8; i++)
            cyc(0, '0, '0, '0, 0, '0, 1, 16'h0020, 4'h3, i[0]);

        // Pseudo-random mix with wrap-around and back-pressure
        r = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s;
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            s = r;
            cyc(s[0], 16'h0100 + 16'(s[2:1]) * 16'd4 + (s[3] ? 16'h8000 : 16'h0000),
                r * 32'h9E3779B9, s[7:4],
                (s[10:8] == 3'd0), s[12:11],
                (s[14:13] != 2'd0), 16'h0100 + 16'(s[16:15]) * 16'd4 + (s[17] ? 16'h8000 : 16'h0000),
                s[21:18], s[22] | s[23]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule